// File: doc/BRIEF.md
# Event Statistics Counter Bank

This block keeps seven small hardware counters that tally error events seen on the receive and transmit paths of an Ethernet MAC. Each counter advances by one on a single-cycle event pulse from the MAC. Counter sizes are kept small on purpose. Management software is expected to poll the counters often and add their values into wider totals of its own. A read of a counter returns its value and empties it in the same access, so no count is lost between polls.

A 32-bit control word sits next to the counters. It offers four functions:
- Freeze: stops all counting, and any event that arrives in that time is thrown away.
- Clear-all: empties every counter in one write.
- Single-step: a test write that advances every counter by one.
- Warning flag: a shared flag, set once any counter has filled its upper bits.

The bank comes out of reset frozen. Access uses a plain address with one-cycle read and write strobes. Read data is registered and appears on the cycle after the read strobe.

Top module: `stat_bank`

## Requirements
- R1: The counter at index 0 is 16 bits wide. Indexes 1 to 4 are 8 bits wide, and indexes 5 and 6 are 4 bits wide. Each counter adds one per event pulse when counting is allowed. Past its maximum value it wraps to 0; it does not saturate.
- R2: The control word is at byte address 0x5C. Counter k is at address 0x60 + 4·k. A read returns data on `rdata_o` in the cycle after `rd_i`, with counter values zero-extended. A read of any other address returns 0. Writes to counter addresses have no effect.
- R3: A read of a counter returns its value and leaves that counter at 0. If an event for the same counter arrives in the read cycle, the read returns the old value and the counter ends at 1.
- R4: Control bit 1 is freeze. While it is 1, event pulses are discarded and the counter values hold. Events that arrived while frozen are not counted later.
- R5: Writing control bit 2 as 1 sets every counter to 0 and drops the warning. This takes precedence over bit 3 in the same write. Bit 2 always reads back as 0.
- R6: Writing control bit 3 as 1 adds exactly one to every counter, whether or not the bank is frozen. An event pulse in that same cycle does not add a second count. Bit 3 always reads back as 0.
- R7: Control bit 0 and `warn_o` go to 1 when any counter has all of its upper half bits at 1:
  - the top 8 bits for the 16-bit counter;
  - the top 4 bits for an 8-bit counter;
  - the top 2 bits for a 4-bit counter.
  The flag stays set even if the counter wraps. It drops once every counter that raised it has been read or cleared. Writes to bit 0 have no effect.
- R8: After reset every counter is 0, the warning is 0, and the control word reads 0x00000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 7 | One-cycle event pulses, bit k for counter k |
| addr_i | input | 8 | Byte address of the access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| warn_o | output | 1 | Shared overflow warning |

## Verification
The hardest state to reach from the ports is a warning that must outlive the counter's own wrap. The bench therefore drives a 4-bit counter seventeen times. This carries it through its warning region and back round to 1, so the flag has to be remembered after the upper bits are gone. The 8-bit threshold is approached one pulse at a time, with the flag checked at 239 and at 240. The clash of a read and an event in one cycle is forced by raising both strobes on the same clock, because it cannot happen by chance in a polled sequence.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

   localparam int NUM_CNT = 7;
   localparam int VAL_W   = 16;

   // control word bit positions (software decodes these)
   localparam int CTL_WARN_BIT   = 0;
   localparam int CTL_FREEZE_BIT = 1;
   localparam int CTL_CLEAR_BIT  = 2;
   localparam int CTL_STEP_BIT   = 3;

   // width of counter idx
   function automatic int cnt_width(input int idx);
      case (idx)
         0:       return 16;
         5, 6:    return 4;
         default: return 8;
      endcase
   endfunction

   // number of upper bits that form the warning threshold
   function automatic int warn_span(input int idx);
      return cnt_width(idx) / 2;
   endfunction

endpackage

// File: rtl/stat_bank_counter.sv
module stat_bank_counter #(
   parameter int CNT_W  = 8,
   parameter int WARN_W = 4,
   parameter int VAL_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic             rd_clr,
   input  logic             clr_all,
   output logic [VAL_W-1:0] value_o,
   output logic             warn_o
);

   generate
      if (WARN_W < 1 || WARN_W > CNT_W) begin : g_bad_warn
         $error("stat_bank_counter: WARN_W must lie in 1..CNT_W");
      end
      if (CNT_W > VAL_W) begin : g_bad_width
         $error("stat_bank_counter: CNT_W exceeds VAL_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_base;
   logic [CNT_W-1:0] cnt_d;
   logic             flag_q;
   logic             flag_d;

   always_comb begin
      cnt_base = (rd_clr || clr_all) ? '0 : cnt_q;
      cnt_d    = clr_all ? '0 : cnt_base + CNT_W'(count_en);
      flag_d   = !clr_all &&
                 ((flag_q && !rd_clr) || (&cnt_d[CNT_W-1 -: WARN_W]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         flag_q <= flag_d;
      end
   end

   generate
      if (VAL_W == CNT_W) begin : g_same
         assign value_o = cnt_q;
      end else begin : g_pad
         assign value_o = {{(VAL_W-CNT_W){1'b0}}, cnt_q};
      end
   endgenerate

   assign warn_o = flag_q;

endmodule

// File: rtl/stat_bank_ctrl.sv
module stat_bank_ctrl
   import stat_bank_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit RESET_FREEZE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   input  logic              warn_any,
   output logic              freeze_o,
   output logic              clr_all_o,
   output logic              step_o,
   output logic [DATA_W-1:0] status_o
);

   generate
      if (DATA_W <= CTL_STEP_BIT) begin : g_bad_dw
         $error("stat_bank_ctrl: DATA_W too narrow for control bits");
      end
   endgenerate

   logic freeze_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         freeze_q <= RESET_FREEZE;
      else if (wr_hit)
         freeze_q <= wdata[CTL_FREEZE_BIT];
   end

   assign clr_all_o = wr_hit && wdata[CTL_CLEAR_BIT];
   assign step_o    = wr_hit && wdata[CTL_STEP_BIT];
   assign freeze_o  = freeze_q;

   always_comb begin
      status_o                 = '0;
      status_o[CTL_WARN_BIT]   = warn_any;
      status_o[CTL_FREEZE_BIT] = freeze_q;
   end

endmodule

// File: rtl/stat_bank_decode.sv
module stat_bank_decode #(
   parameter int ADDR_W    = 8,
   parameter int NUM_CNT   = 7,
   parameter int CTRL_ADDR = 32'h5C,
   parameter int CNT_BASE  = 32'h60
) (
   input  logic [ADDR_W-1:0]  addr_i,
   output logic               ctrl_hit_o,
   output logic [NUM_CNT-1:0] cnt_hit_o
);

   localparam int LAST_ADDR = CNT_BASE + 4 * (NUM_CNT - 1);

   generate
      if (LAST_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_map
         $error("stat_bank_decode: register map exceeds address width");
      end
      if (CTRL_ADDR >= CNT_BASE && CTRL_ADDR <= LAST_ADDR) begin : g_overlap
         $error("stat_bank_decode: control word overlaps counter window");
      end
   endgenerate

   assign ctrl_hit_o = (addr_i == ADDR_W'(CTRL_ADDR));

   generate
      for (genvar k = 0; k < NUM_CNT; k++) begin : g_hit
         assign cnt_hit_o[k] = (addr_i == ADDR_W'(CNT_BASE + 4 * k));
      end
   endgenerate

endmodule

// File: rtl/stat_bank.sv
module stat_bank
   import stat_bank_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_CNT   = stat_bank_pkg::NUM_CNT,
   parameter int VAL_W     = stat_bank_pkg::VAL_W,
   parameter int CTRL_ADDR = 32'h5C,
   parameter int CNT_BASE  = 32'h60
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CNT-1:0] event_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_i,
   input  logic               rd_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               warn_o
);

   generate
      if (DATA_W < VAL_W) begin : g_bad_data
         $error("stat_bank: DATA_W narrower than counter values");
      end
   endgenerate

   logic                     freeze;
   logic                     clr_all;
   logic                     step;
   logic                     ctrl_hit;
   logic [NUM_CNT-1:0]       cnt_hit;
   logic [NUM_CNT-1:0]       rd_clr;
   logic [NUM_CNT-1:0]       inc;
   logic [NUM_CNT-1:0]       warn_vec;
   logic [VAL_W-1:0]         cnt_val [NUM_CNT];
   logic [NUM_CNT*VAL_W-1:0] cnt_flat;
   logic [DATA_W-1:0]        status;
   logic [DATA_W-1:0]        rd_mux;
   logic [DATA_W-1:0]        rdata_q;

   stat_bank_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_CNT  (NUM_CNT),
      .CTRL_ADDR(CTRL_ADDR),
      .CNT_BASE (CNT_BASE)
   ) u_decode (
      .addr_i    (addr_i),
      .ctrl_hit_o(ctrl_hit),
      .cnt_hit_o (cnt_hit)
   );

   stat_bank_ctrl #(
      .DATA_W      (DATA_W),
      .RESET_FREEZE(1'b1)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_i && ctrl_hit),
      .wdata    (wdata_i),
      .warn_any (warn_o),
      .freeze_o (freeze),
      .clr_all_o(clr_all),
      .step_o   (step),
      .status_o (status)
   );

   generate
      for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
         assign inc[k]    = (event_i[k] && !freeze) || step;
         assign rd_clr[k] = rd_i && cnt_hit[k];

         stat_bank_counter #(
            .CNT_W (cnt_width(k)),
            .WARN_W(warn_span(k)),
            .VAL_W (VAL_W)
         ) u_counter (
            .clk     (clk),
            .rst_n   (rst_n),
            .count_en(inc[k]),
            .rd_clr  (rd_clr[k]),
            .clr_all (clr_all),
            .value_o (cnt_val[k]),
            .warn_o  (warn_vec[k])
         );

         assign cnt_flat[k*VAL_W +: VAL_W] = cnt_val[k];
      end
   endgenerate

   always_comb begin
      rd_mux = ctrl_hit ? status : '0;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (cnt_hit[k])
            rd_mux = rd_mux | DATA_W'(cnt_val[k]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_i)
         rdata_q <= rd_mux;
   end

   assign rdata_o = rdata_q;
   assign warn_o  = |warn_vec;

endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
   parameter int NUM_CNT = 7,
   parameter int VAL_W   = 16,
   parameter int DATA_W  = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     rd_i,
   input logic                     ctrl_hit,
   input logic [NUM_CNT-1:0]       cnt_hit,
   input logic                     freeze,
   input logic                     clr_all,
   input logic                     step,
   input logic [NUM_CNT*VAL_W-1:0] cnt_flat,
   input logic [DATA_W-1:0]        rdata_o,
   input logic                     warn_o
);

   assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !step && !clr_all && !rd_i) |=> $stable(cnt_flat));

   assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (cnt_flat == '0));

   assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && cnt_hit[0]) |=> (cnt_flat[VAL_W-1:0] <= VAL_W'(1)));

   assert_step_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr_all && !rd_i) |=>
      (cnt_flat[VAL_W-1:0] == VAL_W'($past(cnt_flat[VAL_W-1:0]) + 1'b1)));

   assert_ctrl_readback_R5_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && ctrl_hit) |=> (rdata_o[3:2] == 2'b00 && rdata_o[0] == $past(warn_o)));

   assert_warn_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> !warn_o);

endmodule

bind stat_bank stat_bank_chk #(
   .NUM_CNT(NUM_CNT),
   .VAL_W  (VAL_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_i    (rd_i),
   .ctrl_hit(ctrl_hit),
   .cnt_hit (cnt_hit),
   .freeze  (freeze),
   .clr_all (clr_all),
   .step    (step),
   .cnt_flat(cnt_flat),
   .rdata_o (rdata_o),
   .warn_o  (warn_o)
);

// File: tb/stat_bank_bench.sv
module stat_bank_bench;

   localparam int BW  [7] = '{16, 8, 8, 8, 8, 4, 4};
   localparam int BWB [7] = '{8, 4, 4, 4, 4, 2, 2};

   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  event_i;
   logic [7:0]  addr_i;
   logic        wr_i;
   logic        rd_i;
   logic [31:0] wdata_i;
   logic [31:0] rdata_o;
   logic        warn_o;

   always #5 clk = ~clk;

   stat_bank u_stat_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .event_i(event_i),
      .addr_i (addr_i),
      .wr_i   (wr_i),
      .rd_i   (rd_i),
      .wdata_i(wdata_i),
      .rdata_o(rdata_o),
      .warn_o (warn_o)
   );

   int    total = 0;
   int    bad   = 0;
   int    exp_q [$];
   string tag_q [$];
   int    mdl [7];
   bit    flg [7];
   bit    frz;
   bit    done = 0;

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void bump(input int k);
      mdl[k] = (mdl[k] + 1) % (1 << BW[k]);
      if ((mdl[k] >> (BW[k] - BWB[k])) == (1 << BWB[k]) - 1)
         flg[k] = 1'b1;
   endfunction

   function automatic int warn_exp();
      int w = 0;
      for (int k = 0; k < 7; k++) if (flg[k]) w = 1;
      return w;
   endfunction

   task automatic cyc(input logic [6:0] ev, input logic wr, input logic rd,
                      input logic [7:0] a, input logic [31:0] d);
      event_i = ev; wr_i = wr; rd_i = rd; addr_i = a; wdata_i = d;
      @(negedge clk);
      event_i = '0; wr_i = 1'b0; rd_i = 1'b0; addr_i = '0; wdata_i = '0;
   endtask

   task automatic events(input logic [6:0] mask, input int n);
      for (int j = 0; j < n; j++) begin
         for (int k = 0; k < 7; k++) if (mask[k] && !frz) bump(k);
         cyc(mask, 1'b0, 1'b0, 8'h00, 32'h0);
      end
   endtask

   task automatic wr_ctrl(input logic [31:0] v, input logic [6:0] ev);
      if (v[2]) begin
         for (int k = 0; k < 7; k++) begin mdl[k] = 0; flg[k] = 1'b0; end
      end else begin
         for (int k = 0; k < 7; k++) if (v[3] || (ev[k] && !frz)) bump(k);
      end
      frz = v[1];
      cyc(ev, 1'b1, 1'b0, 8'h5C, v);
   endtask

   // driver: push expectation, issue read strobe
   task automatic rd_addr(input logic [7:0] a, input int exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      cyc(7'h0, 1'b0, 1'b1, a, 32'h0);
   endtask

   task automatic rd_ctrl(input string tag);
      rd_addr(8'h5C, (int'(frz) << 1) | warn_exp(), tag);
   endtask

   task automatic rd_cnt(input int k, input string tag);
      int e = mdl[k];
      mdl[k] = 0; flg[k] = 1'b0;
      rd_addr(8'(8'h60 + 4 * k), e, tag);
   endtask

   task automatic rd_cnt_ev(input int k, input string tag);
      int e = mdl[k];
      mdl[k] = 0; flg[k] = 1'b0;
      if (!frz) bump(k);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      cyc(7'(1 << k), 1'b0, 1'b1, 8'(8'h60 + 4 * k), 32'h0);
   endtask

   // monitor: compare registered read data one cycle after each strobe
   initial begin
      forever begin
         @(posedge clk);
         if (rd_i) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               check("R2 unexpected read", 1, 0);
            end else begin
               check(tag_q.pop_front(), int'(rdata_o), exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; event_i = '0; addr_i = '0; wr_i = 1'b0; rd_i = 1'b0; wdata_i = '0;
      for (int k = 0; k < 7; k++) begin mdl[k] = 0; flg[k] = 1'b0; end
      frz = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      check("R8 warn after reset", int'(warn_o), 0);
      rd_ctrl("R8 ctrl reset value");
      rd_cnt(0, "R8 counter0 reset");

      // R4 frozen at reset: events discarded
      events(7'h7F, 5);
      rd_cnt(0, "R4 frozen drops events c0");
      rd_cnt(6, "R4 frozen drops events c6");

      // R1 R2 R3 counting, map order, read clear
      wr_ctrl(32'h0, 7'h0);
      events(7'h7F, 3);
      for (int k = 0; k < 7; k++) rd_cnt(k, "R1 R2 count per counter");
      rd_cnt(2, "R3 second read after clear");

      // R1 16-bit width beyond 255
      events(7'h01, 300);
      rd_cnt(0, "R1 wide counter 300");

      // R2 unmapped read and ignored counter write
      events(7'h02, 2);
      cyc(7'h0, 1'b1, 1'b0, 8'h64, 32'hFF);
      rd_cnt(1, "R2 counter write ignored");
      rd_addr(8'h80, 0, "R2 unmapped read");

      // R1 R7 wrap of 4-bit counter keeps warning sticky
      events(7'h20, 17);
      check("R7 sticky warn after wrap", int'(warn_o), warn_exp());
      rd_cnt(5, "R1 4-bit wrap value");
      @(negedge clk);
      check("R7 warn cleared by read", int'(warn_o), 0);

      // R3 read and event in same cycle
      events(7'h01, 4);
      rd_cnt_ev(0, "R3 read with event old value");
      rd_cnt(0, "R3 counter ends at 1");

      // R7 8-bit threshold boundary
      events(7'h02, 239);
      check("R7 no warn at 239", int'(warn_o), 0);
      events(7'h02, 1);
      check("R7 warn at 240", int'(warn_o), 1);
      wr_ctrl(32'h1, 7'h0);
      rd_ctrl("R7 bit0 write ignored");
      wr_ctrl(32'h4, 7'h0);
      check("R5 R7 clear-all drops warn", int'(warn_o), 0);
      rd_cnt(1, "R5 clear-all empties counter");

      // R6 strobe while frozen
      wr_ctrl(32'hA, 7'h0);
      rd_ctrl("R6 strobe reads back 0");
      rd_cnt(0, "R6 strobe frozen c0");
      rd_cnt(6, "R6 strobe frozen c6");

      // R6 strobe with event in same cycle gives one count
      wr_ctrl(32'h0, 7'h0);
      wr_ctrl(32'h8, 7'h02);
      rd_cnt(1, "R6 strobe plus event single count");

      // R5 clear wins over strobe
      events(7'h10, 5);
      wr_ctrl(32'hC, 7'h0);
      rd_cnt(4, "R5 clear beats strobe");
      wr_ctrl(32'h4, 7'h0);
      rd_ctrl("R5 clear bit reads 0");

      repeat (3) @(negedge clk);
      check("R2 all reads answered", exp_q.size(), 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule